// File: doc/BRIEF.md
# Message Frame Queue Unit

This unit keeps four circular lists of 32-bit message frame addresses. Two lists carry traffic toward the local processor: a free list of empty inbound frames and a post list of filled ones. Two lists carry traffic toward the host: a free list of returned outbound frames and a post list of completed ones. All list entries sit in one internal dual-port RAM. The RAM is split into two halves, and each list occupies a slice found from a base register, the list index and the configured queue size.

Both sides reach the unit through one word-addressed register interface. Only the `loc_side` input says which side is making the access. Two queue ports send each access to a list according to its direction and its side. A read pops the next address from one list, and a write pushes an address onto another. A global enable bit gates the whole port path. Software can read and write every head and tail pointer directly. A registered interrupt tells the host that the outbound post list holds entries.

Top module: `mfq_unit`

## Requirements
- R1: After reset, every register reads 0, including the control word at E8h, the size code at C0h and the interrupt status at 30h. `irq` is 0.
- R2: While the enable bit (bit 0 at E8h) is 0, port accesses at 40h and 44h move no pointer and store nothing, and a port read returns 0.
- R3: A host write to 40h pushes onto the inbound post list (list 1, head D0h, tail D4h). A local read of 40h pops from that list in FIFO order.
- R4: A local write to 40h pushes onto the inbound free list (list 0, head C8h, tail CCh). A host read of 40h pops from it in FIFO order.
- R5: A local write to 44h pushes onto the outbound post list (list 3, head E0h, tail E4h), and a host read of 44h pops from it. A host write to 44h pushes onto the outbound free list (list 2, head D8h, tail DCh), and a local read of 44h pops from it.
- R6: A list is empty when head equals tail. A pop from an empty list returns FFFFFFFFh and leaves both pointers unchanged.
- R7: A list is full when it holds size-1 entries. A push to a full list is dropped and sets sticky bit 4+list at E8h. Writing 1 to that bit at E8h clears it.
- R8: Queue size is 2 << C0h[1:0] (2, 4, 8 or 16). Pointers advance modulo that size. A software pointer write keeps only value & (size-1).
- R9: The interrupt status at 30h bit 0 is 1 while the outbound post list is non-empty. `irq` equals that status AND NOT the mask bit (34h bit 0), one clock later.
- R10: Undefined bits and unmapped offsets read as 0. Writes to them have no effect.
- R11: Read data and `rd_valid` appear on the clock edge that samples `reg_rd`.
- R12: A slot sits at RAM word {E8h bit 1, (C4h + list*size + pointer) mod half-depth}. The region bit and the base therefore select which storage a list uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_side | input | 1 | 1 = access made by the local processor, 0 = by the host |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | High the cycle after a read strobe |
| irq | output | 1 | Outbound post interrupt, registered |

## Verification
The bench builds the unit with its defaults: 128 RAM words (two halves of 64) and 4-bit pointers. At run time it drives the size code to 4 entries and to 2 entries. The 4-entry setting lets the bench fill a list to its three-entry capacity, wrap the tail to 0 and hit the overflow drop within a handful of accesses. The 2-entry setting, together with a base of 6, makes the inbound free list's first slot alias the outbound post list's first slot. That aliasing lets the bench observe the base and region mapping through the ports.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
  localparam int NLISTS = 4;

  localparam logic [7:0] A_ISTAT    = 8'h30;
  localparam logic [7:0] A_IMASK    = 8'h34;
  localparam logic [7:0] A_PORT_IN  = 8'h40;
  localparam logic [7:0] A_PORT_OUT = 8'h44;
  localparam logic [7:0] A_CFG      = 8'hC0;
  localparam logic [7:0] A_BASE     = 8'hC4;
  localparam logic [7:0] A_PTR0     = 8'hC8;
  localparam logic [7:0] A_CTL      = 8'hE8;

  typedef enum logic [1:0] {
    L_IN_FREE  = 2'd0,
    L_IN_POST  = 2'd1,
    L_OUT_FREE = 2'd2,
    L_OUT_POST = 2'd3
  } list_e;

  // Which list a port access touches: bit 1 is the port, bit 0 the direction/side mix.
  function automatic logic [1:0] route_list(input logic is_out, input logic local_side,
                                            input logic rd, input logic wr);
    return {is_out, is_out ^ (local_side ? rd : wr)};
  endfunction

  function automatic int unsigned queue_size(input logic [1:0] code);
    return 32'd2 << code;
  endfunction

  // Word index of a list slot inside one storage half.
  function automatic int unsigned slot_word(input int unsigned base, input int unsigned lst,
                                            input int unsigned qsize, input int unsigned ptr,
                                            input int unsigned half);
    return (base + lst * qsize + ptr) % half;
  endfunction
endpackage

// File: rtl/mfq_ptr_pair.sv
module mfq_ptr_pair #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] size_mask,
  input  logic             push,
  input  logic             pop,
  input  logic             head_we,
  input  logic             tail_we,
  input  logic [PTR_W-1:0] sw_ptr,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             empty,
  output logic             full,
  output logic             push_drop
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [PTR_W-1:0] head_nx, tail_nx;

  assign head_nx   = (head_q + 1'b1) & size_mask;
  assign tail_nx   = (tail_q + 1'b1) & size_mask;
  assign empty     = (head_q == tail_q);
  assign full      = (tail_nx == head_q);
  assign push_drop = push & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (head_we)              head_q <= sw_ptr & size_mask;
      else if (pop && !empty)   head_q <= head_nx;
      if (tail_we)              tail_q <= sw_ptr & size_mask;
      else if (push && !full)   tail_q <= tail_nx;
    end
  end

  assign head = head_q;
  assign tail = tail_q;

  p_pop_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !head_we && !tail_we) |=> (head_q == $past(head_q)) && (tail_q == $past(tail_q)));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !tail_we) |=> (tail_q == $past(tail_q)));

  p_push_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !tail_we && (size_mask != '0)) |=> (tail_q != $past(tail_q)));
endmodule

// File: rtl/mfq_ram.sv
module mfq_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mfq_irq.sv
module mfq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic mask,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending & ~mask;
  end

  assign irq = irq_q;

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !irq_q);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(pending));
endmodule

// File: rtl/mfq_unit.sv
module mfq_unit #(
  parameter int DW        = 32,
  parameter int RAM_DEPTH = 128,
  parameter int PTR_W     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_side,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rd_valid,
  output logic          irq
);
  import mfq_pkg::*;

  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int HALF   = RAM_DEPTH / 2;
  localparam int HALF_W = RAM_AW - 1;

  // Configuration and control state
  logic [1:0]        cfg_code;
  logic [HALF_W-1:0] base_q;
  logic              q_en, region, imask_q;
  logic [3:0]        ovf_q, ovf_clr;

  // Per-list pointer state
  logic [NLISTS-1:0][PTR_W-1:0] head_q, tail_q;
  logic [NLISTS-1:0] empty_v, full_v, drop_v;
  logic [NLISTS-1:0] push_v, pop_v, head_we, tail_we;

  // Port path events
  logic        is_port, is_out, port_rd, port_wr, ptr_sw_any;
  logic [1:0]  port_lst;
  int unsigned qsize;
  logic [PTR_W-1:0]  size_mask;
  logic [HALF_W-1:0] wr_word, rd_word;
  logic [DW-1:0]     ram_rd, rd_next;
  logic              opl_pend;

  assign is_port  = (reg_addr == A_PORT_IN) || (reg_addr == A_PORT_OUT);
  assign is_out   = (reg_addr == A_PORT_OUT);
  assign port_rd  = reg_rd & is_port & q_en;
  assign port_wr  = reg_wr & is_port & q_en;
  assign port_lst = route_list(is_out, loc_side, reg_rd, reg_wr);

  assign qsize     = queue_size(cfg_code);
  assign size_mask = PTR_W'(qsize - 32'd1);

  genvar gi;
  generate
    for (gi = 0; gi < NLISTS; gi++) begin : g_list
      localparam logic [7:0] HEAD_A = A_PTR0 + 8'(8 * gi);
      localparam logic [7:0] TAIL_A = HEAD_A + 8'd4;

      assign push_v[gi]  = port_wr && (port_lst == 2'(gi));
      assign pop_v[gi]   = port_rd && (port_lst == 2'(gi));
      assign head_we[gi] = reg_wr && (reg_addr == HEAD_A);
      assign tail_we[gi] = reg_wr && (reg_addr == TAIL_A);

      mfq_ptr_pair #(.PTR_W(PTR_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_mask (size_mask),
        .push      (push_v[gi]),
        .pop       (pop_v[gi]),
        .head_we   (head_we[gi]),
        .tail_we   (tail_we[gi]),
        .sw_ptr    (reg_wdata[PTR_W-1:0]),
        .head      (head_q[gi]),
        .tail      (tail_q[gi]),
        .empty     (empty_v[gi]),
        .full      (full_v[gi]),
        .push_drop (drop_v[gi])
      );
    end
  endgenerate

  assign ptr_sw_any = (|head_we) | (|tail_we);
  assign opl_pend   = ~empty_v[L_OUT_POST];

  // Storage addressing
  assign wr_word = HALF_W'(slot_word(32'(base_q), 32'(port_lst), qsize,
                                     32'(tail_q[port_lst]), HALF));
  assign rd_word = HALF_W'(slot_word(32'(base_q), 32'(port_lst), qsize,
                                     32'(head_q[port_lst]), HALF));

  mfq_ram #(.DEPTH(RAM_DEPTH), .DW(DW)) u_ram (
    .clk     (clk),
    .wr_en   (|(push_v & ~full_v)),
    .wr_addr ({region, wr_word}),
    .wr_data (reg_wdata),
    .rd_addr ({region, rd_word}),
    .rd_data (ram_rd)
  );

  // Configuration and control registers
  assign ovf_clr = (reg_wr && reg_addr == A_CTL) ? reg_wdata[7:4] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_code <= '0;
      base_q   <= '0;
      q_en     <= 1'b0;
      region   <= 1'b0;
      imask_q  <= 1'b0;
      ovf_q    <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CFG)   cfg_code <= reg_wdata[1:0];
      if (reg_wr && reg_addr == A_BASE)  base_q   <= reg_wdata[HALF_W-1:0];
      if (reg_wr && reg_addr == A_IMASK) imask_q  <= reg_wdata[0];
      if (reg_wr && reg_addr == A_CTL) begin
        q_en   <= reg_wdata[0];
        region <= reg_wdata[1];
      end
      ovf_q <= (ovf_q & ~ovf_clr) | drop_v;
    end
  end

  // Read path
  always_comb begin
    rd_next = '0;
    unique case (reg_addr)
      A_ISTAT:    rd_next = DW'(opl_pend);
      A_IMASK:    rd_next = DW'(imask_q);
      A_PORT_IN,
      A_PORT_OUT: rd_next = q_en ? (empty_v[port_lst] ? '1 : ram_rd) : '0;
      A_CFG:      rd_next = DW'(cfg_code);
      A_BASE:     rd_next = DW'(base_q);
      A_CTL:      rd_next = DW'({ovf_q, 2'b00, region, q_en});
      default: begin
        for (int i = 0; i < NLISTS; i++) begin
          if (reg_addr == A_PTR0 + 8'(8 * i))       rd_next = DW'(head_q[i]);
          if (reg_addr == A_PTR0 + 8'(8 * i) + 8'd4) rd_next = DW'(tail_q[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_next;
    end
  end

  mfq_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (opl_pend),
    .mask    (imask_q),
    .irq     (irq)
  );

  p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_en && !ptr_sw_any) |=> (head_q == $past(head_q)) && (tail_q == $past(tail_q)));

  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_q & $past(ovf_q & ~ovf_clr)) == $past(ovf_q & ~ovf_clr)));
endmodule

// File: tb/mfq_unit_tb.sv
module mfq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_side = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_valid, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  localparam logic HOST = 1'b0, LOC = 1'b1;

  always #10 clk = ~clk;

  mfq_unit u_dut (.clk(clk), .rst_n(rst_n), .loc_side(loc_side), .reg_rd(reg_rd),
                  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
                  .reg_rdata(reg_rdata), .rd_valid(rd_valid), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic side);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; loc_side = side; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic side,
                        input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a; loc_side = side; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R11 rd_valid", 32'(rd_valid), 32'd1);
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 32'd0);
    rd_chk("R1 ctl", 8'hE8, HOST, 32'h0);
    rd_chk("R1 cfg", 8'hC0, HOST, 32'h0);
    rd_chk("R1 istat", 8'h30, HOST, 32'h0);
    rd_chk("R10 unmapped", 8'h00, HOST, 32'h0);
  endtask

  task automatic t_disabled;
    wr(8'h40, 32'h1111_1111, HOST);
    rd_chk("R2 ip tail", 8'hD4, HOST, 32'h0);
    rd_chk("R2 port read", 8'h40, HOST, 32'h0);
  endtask

  task automatic t_inbound;
    wr(8'hE8, 32'h1, HOST);
    wr(8'hC0, 32'h1, HOST);
    wr(8'h40, 32'hA000_0010, LOC);
    wr(8'h40, 32'hA000_0020, LOC);
    rd_chk("R4 pop1", 8'h40, HOST, 32'hA000_0010);
    rd_chk("R4 pop2", 8'h40, HOST, 32'hA000_0020);
    rd_chk("R4 if head", 8'hC8, HOST, 32'h2);
    wr(8'h40, 32'hC000_0030, HOST);
    rd_chk("R3 pop", 8'h40, LOC, 32'hC000_0030);
    rd_chk("R3 ip head", 8'hD0, HOST, 32'h1);
  endtask

  task automatic t_empty;
    rd_chk("R6 empty pop", 8'h40, HOST, 32'hFFFF_FFFF);
    rd_chk("R6 head", 8'hC8, HOST, 32'h2);
    rd_chk("R6 tail", 8'hCC, HOST, 32'h2);
  endtask

  task automatic t_outbound;
    rd_chk("R9 status idle", 8'h30, HOST, 32'h0);
    wr(8'h44, 32'hD000_0040, LOC);
    rd_chk("R9 status", 8'h30, HOST, 32'h1);
    chk("R9 irq up", 32'(irq), 32'd1);
    wr(8'h34, 32'h1, HOST);
    @(negedge clk);
    chk("R9 masked", 32'(irq), 32'd0);
    wr(8'h34, 32'h0, HOST);
    @(negedge clk);
    chk("R9 unmasked", 32'(irq), 32'd1);
    rd_chk("R5 op pop", 8'h44, HOST, 32'hD000_0040);
    @(negedge clk);
    chk("R9 irq down", 32'(irq), 32'd0);
    wr(8'h44, 32'hE000_0050, HOST);
    rd_chk("R5 of pop", 8'h44, LOC, 32'hE000_0050);
    rd_chk("R5 op head", 8'hE0, HOST, 32'h1);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) wr(8'h40, 32'hF000_0000 + 32'(i), HOST);
    rd_chk("R7 ovf bit", 8'hE8, HOST, 32'h21);
    rd_chk("R8 tail wrap", 8'hD4, HOST, 32'h0);
    for (int i = 0; i < 3; i++) rd_chk("R7 fifo", 8'h40, LOC, 32'hF000_0000 + 32'(i));
    rd_chk("R7 dropped", 8'h40, LOC, 32'hFFFF_FFFF);
    wr(8'hE8, 32'h21, HOST);
    rd_chk("R7 clear", 8'hE8, HOST, 32'h1);
  endtask

  task automatic t_mask_bits;
    wr(8'hC8, 32'hFF, HOST);
    rd_chk("R8 ptr mask", 8'hC8, HOST, 32'h3);
    wr(8'hC8, 32'h2, HOST);
    wr(8'hC0, 32'hFFFF_FFFC, HOST);
    rd_chk("R10 cfg bits", 8'hC0, HOST, 32'h0);
    wr(8'h34, 32'hFFFF_FFFE, HOST);
    rd_chk("R10 mask bits", 8'h34, HOST, 32'h0);
    rd_chk("R10 gap", 8'h48, HOST, 32'h0);
  endtask

  task automatic t_region;
    for (int i = 0; i < 8; i++) wr(8'hC8 + 8'(4 * i), 32'h0, HOST);
    wr(8'h44, 32'h5A5A_0001, LOC);
    rd_chk("R12 r0 pop", 8'h44, HOST, 32'h5A5A_0001);
    wr(8'hE8, 32'h3, HOST);
    wr(8'hE0, 32'h0, HOST);
    wr(8'hE4, 32'h0, HOST);
    wr(8'h44, 32'hA5A5_0002, LOC);
    wr(8'hE8, 32'h1, HOST);
    wr(8'hC4, 32'h6, HOST);
    wr(8'hC8, 32'h0, HOST);
    wr(8'hCC, 32'h1, HOST);
    rd_chk("R12 base alias r0", 8'h40, HOST, 32'h5A5A_0001);
    wr(8'hE8, 32'h3, HOST);
    wr(8'hC8, 32'h0, HOST);
    wr(8'hCC, 32'h1, HOST);
    rd_chk("R12 base alias r1", 8'h40, HOST, 32'hA5A5_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_inbound();
    t_empty();
    t_outbound();
    t_full();
    t_mask_bits();
    t_region();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule